// File: doc/BRIEF.md
# Buffered Serial Audio Transmitter

This block sends stereo audio over a three-wire I2S link. Software writes sixteen left/right sample pairs into a 32-word buffer through a small register port. The core then sends the samples MSB first on the serial data line, one 32-bit slot per channel. The buffer is used as two halves. A status bit and an interrupt mark each half as it is drained, so software can refill that half while the other half plays.

The elaboration parameter `MASTER` selects the variant. In master mode the core makes the bit clock and word select from the system clock through a programmable divider. In slave mode it follows an external bit clock and word select, which pass through a two-stage synchroniser.

The transmit sequencer is a three-state machine:
- **TX_OFF**: transmission is disabled. Data is held low and the frame pointer is held at frame 0. It leaves on **start** (enable bit written to 1) and goes to TX_SYNC.
- **TX_SYNC**: the sequencer waits for alignment. On **align** (word select seen low at a bit-clock falling edge) it loads the left sample of frame 0 and goes to TX_RUN.
- **TX_RUN**: samples are shifted out, and a new word is loaded at every word-select change.

From either TX_SYNC or TX_RUN, **stop** (enable bit cleared) returns the sequencer to TX_OFF.

Top module: `i2s_tx_core`

## Requirements
- R1: A bus access is strobed by `bus_stb`. `bus_ack` is high for exactly one cycle, in the cycle after the strobe is first seen, and writes take effect at that same edge. Reading word offset 0 returns 0x1B1 in the master variant and 0x191 in the slave variant.
- R2: Word offsets 0x20 to 0x3F hold the sample buffer and read back what was written. Offset 0x20+2k is the left sample of frame k, and 0x20+2k+1 is its right sample.
- R3: In master mode, configuration (offset 1) bits 15:8 hold N, and `sck_out` toggles every N+1 system clocks while bit 0 (enable) is set. While enable is clear, `sck_out` is held low.
- R4: In master mode, `ws_out` is low for the left slot and high for the right slot. It changes only on a falling edge of `sck_out`, once every 32 falling edges. While disabled it is held high, so that the first falling edge after enabling starts a left slot.
- R5: Configuration bits 23:16 give the resolution R (16, 20 or 24). Each slot carries the low R bits of its buffer word, MSB first, followed by zeros. The MSB is valid at the second rising edge of the bit clock after the word-select change, and data changes only after falling edges.
- R6: While enable is clear, `sd_out` is low and the frame pointer returns to 0. After enabling, the first slot sent is the left sample of frame 0.
- R7: Status (offset 3) bit 0 is set one system clock after word select rises for the right slot of frame 7. Bit 1 is set in the same way for frame 15, and the pointer then wraps to frame 0.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the set wins.
- R9: `irq` equals configuration bit 1 AND the OR of (status AND mask), where the mask is offset 2, bits 1:0.
- R10: In slave mode, the core follows `sck_in`/`ws_in` through a two-flop synchroniser. Its `sd_out` equals the master's output two system clocks later when both are fed the same link and the same writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_stb | input | 1 | Bus strobe |
| bus_we | input | 1 | Write enable |
| bus_addr | input | ADDR_W | Word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_ack | output | 1 | One-cycle acknowledge |
| bus_rdata | output | DATA_W | Read data, valid with ack |
| irq | output | 1 | Interrupt request |
| sck_in | input | 1 | External bit clock (slave variant) |
| ws_in | input | 1 | External word select (slave variant) |
| sck_out | output | 1 | Generated bit clock (master variant, else 0) |
| ws_out | output | 1 | Generated word select (master variant, else 0) |
| sd_out | output | 1 | Serial data |

## Verification
The one collision this block can hit is a half-drained status set meeting a software write-1-clear of the same bit at the same clock edge. The bench counts word-select rises from enable and, on the sixteenth, issues a status clear so that the write lands on exactly the edge where the frame-15 set occurs. Its cycle model applies the set after the clear, so `irq` must stay high and a later read must still return the bit. Every other clock, the model also compares acknowledge, interrupt and serial bits, and compares the slave copy's data against the master's data delayed by two cycles.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;
    typedef enum logic [1:0] {
        TX_OFF  = 2'd0,
        TX_SYNC = 2'd1,
        TX_RUN  = 2'd2
    } tx_state_e;

    localparam logic [31:0] VER_MASTER = 32'h0000_01B1;
    localparam logic [31:0] VER_SLAVE  = 32'h0000_0191;

    localparam int REG_VER  = 0;
    localparam int REG_CFG  = 1;
    localparam int REG_MASK = 2;
    localparam int REG_STAT = 3;
endpackage

// File: rtl/i2s_tx_regs.sv
module i2s_tx_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int WORDS  = 32,
    parameter logic [DATA_W-1:0] VERSION = '0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     stb,
    input  logic                     we,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [DATA_W-1:0]        wdata,
    output logic                     ack,
    output logic [DATA_W-1:0]        rdata,
    output logic [DATA_W-1:0]        cfg,
    input  logic [$clog2(WORDS)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_word,
    input  logic [1:0]               set_half,
    output logic                     irq
);
    import i2s_tx_pkg::*;
    localparam int IDX_W = $clog2(WORDS);

    logic [DATA_W-1:0] mem [WORDS];
    logic [1:0]        mask;
    logic [1:0]        status;
    logic              take;
    logic              buf_sel;
    logic              wr_stat;
    logic [1:0]        clr;
    logic [DATA_W-1:0] rd_val;

    assign take    = stb & ~ack;
    assign buf_sel = addr[ADDR_W-1];
    assign wr_stat = take & we & ~buf_sel & (addr == ADDR_W'(REG_STAT));
    assign clr     = wr_stat ? wdata[1:0] : 2'b00;
    assign rd_word = mem[rd_idx];
    assign irq     = cfg[1] & |(status & mask);

    always_comb begin
        rd_val = '0;
        if (buf_sel) begin
            rd_val = mem[addr[IDX_W-1:0]];
        end else begin
            unique case (addr)
                ADDR_W'(REG_VER):  rd_val = VERSION;
                ADDR_W'(REG_CFG):  rd_val = cfg;
                ADDR_W'(REG_MASK): rd_val = {{(DATA_W-2){1'b0}}, mask};
                ADDR_W'(REG_STAT): rd_val = {{(DATA_W-2){1'b0}}, status};
                default:           rd_val = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack    <= 1'b0;
            rdata  <= '0;
            cfg    <= '0;
            mask   <= 2'b00;
            status <= 2'b00;
        end else begin
            ack <= take;
            if (take) rdata <= rd_val;
            if (take && we && !buf_sel && addr == ADDR_W'(REG_CFG))  cfg  <= wdata;
            if (take && we && !buf_sel && addr == ADDR_W'(REG_MASK)) mask <= wdata[1:0];
            status <= (status & ~clr) | set_half;
        end
    end

    always_ff @(posedge clk) begin
        if (take && we && buf_sel) mem[addr[IDX_W-1:0]] <= wdata;
    end

    a_r1_ack_after_stb: assert property (@(posedge clk) disable iff (rst)
        ack |-> $past(stb));
    a_r7_set_sticks: assert property (@(posedge clk) disable iff (rst)
        (set_half != 2'b00) |=> ((status & $past(set_half)) == $past(set_half)));
    a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && wdata[0] && !set_half[0]) |=> !status[0]);
endmodule

// File: rtl/i2s_tx_clkgen.sv
module i2s_tx_clkgen #(
    parameter int DIV_W     = 8,
    parameter int SLOT_BITS = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div,
    output logic             sck,
    output logic             ws
);
    localparam int BW = $clog2(SLOT_BITS);
    localparam logic [BW-1:0] LAST = BW'(SLOT_BITS - 1);

    logic [DIV_W-1:0] cnt;
    logic [BW-1:0]    bitc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt  <= '0;
            sck  <= 1'b0;
            ws   <= 1'b1;
            bitc <= LAST;
        end else if (cnt == div) begin
            cnt <= '0;
            sck <= ~sck;
            if (sck) begin
                bitc <= (bitc == LAST) ? '0 : bitc + 1'b1;
                if (bitc == LAST) ws <= ~ws;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    a_r3_idle_clock: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!sck && ws));
    a_r4_ws_on_fall: assert property (@(posedge clk) disable iff (rst)
        ($past(en) && ws != $past(ws)) |-> $fell(sck));
endmodule

// File: rtl/i2s_tx_serial.sv
module i2s_tx_serial #(
    parameter int DATA_W = 32,
    parameter int FRAMES = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         en,
    input  logic [7:0]                   res,
    input  logic                         sck,
    input  logic                         ws,
    output logic [$clog2(2*FRAMES)-1:0]  rd_idx,
    input  logic [DATA_W-1:0]            rd_word,
    output logic                         sd,
    output logic [1:0]                   half_set
);
    import i2s_tx_pkg::*;
    localparam int FR_W = $clog2(FRAMES);
    localparam logic [FR_W-1:0] HALF_LO = FR_W'(FRAMES/2 - 1);
    localparam logic [FR_W-1:0] LAST    = FR_W'(FRAMES - 1);

    tx_state_e         state, state_nx;
    logic              sck_q;
    logic              ws_last;
    logic [FR_W-1:0]   frame;
    logic [DATA_W-1:0] shreg;
    logic [7:0]        res_c;
    logic [7:0]        shamt;
    logic [DATA_W-1:0] load_word;
    logic              tick, wchg, run_ok;

    assign tick      = sck_q & ~sck;
    assign wchg      = tick & (ws != ws_last);
    assign rd_idx    = {frame, ws};
    assign res_c     = (res > 8'(DATA_W)) ? 8'(DATA_W) : res;
    assign shamt     = 8'(DATA_W) - res_c;
    assign load_word = rd_word << shamt;
    assign run_ok    = en && state == TX_RUN;
    assign half_set  = (run_ok && wchg && ws) ? {frame == LAST, frame == HALF_LO} : 2'b00;

    always_comb begin
        state_nx = state;
        unique case (state)
            TX_OFF:  if (en) state_nx = TX_SYNC;
            TX_SYNC: if (!en) state_nx = TX_OFF;
                     else if (wchg && !ws) state_nx = TX_RUN;
            TX_RUN:  if (!en) state_nx = TX_OFF;
            default: state_nx = TX_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= TX_OFF;
        else     state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b0;
            ws_last <= 1'b1;
            frame   <= '0;
            shreg   <= '0;
            sd      <= 1'b0;
        end else begin
            sck_q <= sck;
            if (tick || state == TX_OFF) ws_last <= ws;
            if (!en || state == TX_OFF) begin
                sd    <= 1'b0;
                frame <= '0;
                shreg <= '0;
            end else begin
                unique case (state)
                    TX_SYNC: begin
                        sd <= 1'b0;
                        if (wchg && !ws) shreg <= load_word;
                    end
                    TX_RUN: if (tick) begin
                        sd    <= shreg[DATA_W-1];
                        shreg <= wchg ? load_word : (shreg << 1);
                        if (wchg && ws) frame <= (frame == LAST) ? '0 : frame + 1'b1;
                    end
                    default: sd <= 1'b0;
                endcase
            end
        end
    end

    a_r6_idle_low: assert property (@(posedge clk) disable iff (rst)
        !en |=> !sd);
    a_r7_half_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(half_set));
    a_r6_frame_reset: assert property (@(posedge clk) disable iff (rst)
        (state == TX_OFF) |=> (frame == '0));
endmodule

// File: rtl/i2s_tx_core.sv
module i2s_tx_core #(
    parameter bit MASTER = 1'b1,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int FRAMES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_stb,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              sck_in,
    input  logic              ws_in,
    output logic              sck_out,
    output logic              ws_out,
    output logic              sd_out
);
    import i2s_tx_pkg::*;
    localparam int WORDS = 2 * FRAMES;
    localparam int IDX_W = $clog2(WORDS);
    localparam logic [DATA_W-1:0] VERSION = MASTER ? DATA_W'(VER_MASTER) : DATA_W'(VER_SLAVE);

    logic [DATA_W-1:0] cfg;
    logic [IDX_W-1:0]  rd_idx;
    logic [DATA_W-1:0] rd_word;
    logic [1:0]        half_set;
    logic              ser_sck, ser_ws;
    logic              unused_cfg;

    assign unused_cfg = ^{cfg[DATA_W-1:24], cfg[7:2]};

    i2s_tx_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .WORDS(WORDS), .VERSION(VERSION)) u_regs (
        .clk(clk), .rst(rst), .stb(bus_stb), .we(bus_we), .addr(bus_addr),
        .wdata(bus_wdata), .ack(bus_ack), .rdata(bus_rdata), .cfg(cfg),
        .rd_idx(rd_idx), .rd_word(rd_word), .set_half(half_set), .irq(irq)
    );

    generate
        if (MASTER) begin : g_master
            logic unused_pins;
            assign unused_pins = sck_in ^ ws_in;
            i2s_tx_clkgen #(.DIV_W(8), .SLOT_BITS(DATA_W)) u_clk (
                .clk(clk), .rst(rst), .en(cfg[0]), .div(cfg[15:8]),
                .sck(ser_sck), .ws(ser_ws)
            );
            assign sck_out = ser_sck;
            assign ws_out  = ser_ws;
        end else begin : g_slave
            logic [1:0] sck_s, ws_s;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sck_s <= 2'b00;
                    ws_s  <= 2'b11;
                end else begin
                    sck_s <= {sck_s[0], sck_in};
                    ws_s  <= {ws_s[0], ws_in};
                end
            end
            assign ser_sck = sck_s[1];
            assign ser_ws  = ws_s[1];
            assign sck_out = 1'b0;
            assign ws_out  = 1'b0;
        end
    endgenerate

    i2s_tx_serial #(.DATA_W(DATA_W), .FRAMES(FRAMES)) u_ser (
        .clk(clk), .rst(rst), .en(cfg[0]), .res(cfg[23:16]),
        .sck(ser_sck), .ws(ser_ws), .rd_idx(rd_idx), .rd_word(rd_word),
        .sd(sd_out), .half_set(half_set)
    );

    a_r9_irq_gated: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(irq)) |-> cfg[1]);
endmodule

// File: tb/i2s_tx_core_test.sv
module i2s_tx_core_test;
    localparam int CLK_P = 10;
    localparam int WDOG  = 150000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic stb = 1'b0, we = 1'b0;
    logic [5:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic        ack, irq, sck, ws, sd;
    logic [31:0] rdata;
    logic        ack_s, irq_s, sck_s_o, ws_s_o, sd_s;
    logic [31:0] rdata_s;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #(CLK_P/2) clk = ~clk;

    i2s_tx_core #(.MASTER(1'b1)) uut (
        .clk(clk), .rst(rst), .bus_stb(stb), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_ack(ack), .bus_rdata(rdata), .irq(irq),
        .sck_in(1'b0), .ws_in(1'b1), .sck_out(sck), .ws_out(ws), .sd_out(sd)
    );

    i2s_tx_core #(.MASTER(1'b0)) uut_s (
        .clk(clk), .rst(rst), .bus_stb(stb), .bus_we(we), .bus_addr(addr),
        .bus_wdata(wdata), .bus_ack(ack_s), .bus_rdata(rdata_s), .irq(irq_s),
        .sck_in(sck), .ws_in(ws), .sck_out(sck_s_o), .ws_out(ws_s_o), .sd_out(sd_s)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    // bus inputs as seen by the design at each rising edge
    logic p_stb = 1'b0, p_we = 1'b0;
    logic [5:0]  p_addr = '0;
    logic [31:0] p_wdata = '0;
    always @(posedge clk) begin
        p_stb <= stb; p_we <= we; p_addr <= addr; p_wdata <= wdata;
        cycles <= cycles + 1;
    end

    // behavioural reference model, evaluated once per clock
    logic        ack_m;
    logic [31:0] cfg_m;
    logic [1:0]  mask_m, status_m, pend, clr;
    logic [31:0] buf_m [32];
    logic [31:0] cur;
    logic        sck_p, ws_p, sd_d1, sd_d2;
    logic [3:0]  en_hist;
    int f, rise_cnt, since_tog, falls;
    bit waiting, running, first_ws;

    function automatic logic [31:0] exp_word(input int idx);
        int r;
        r = int'(cfg_m[23:16]);
        return buf_m[idx] << (32 - r);
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            ack_m = 0; cfg_m = 0; mask_m = 0; status_m = 0; pend = 0;
            sck_p = 0; ws_p = 1; sd_d1 = 0; sd_d2 = 0; en_hist = 0;
            f = 0; rise_cnt = 0; since_tog = 0; falls = 0;
            waiting = 0; running = 0; first_ws = 0; cur = 0;
        end else begin
            logic old_ack, rise, fall, exp_irq, exp_bit;
            old_ack = ack_m;
            ack_m = p_stb & ~old_ack;
            clr = 2'b00;
            if (p_stb && !old_ack && p_we) begin
                if (p_addr[5]) buf_m[p_addr[4:0]] = p_wdata;
                else case (p_addr)
                    6'd1: begin
                        if (p_wdata[0] && !cfg_m[0]) begin
                            waiting = 1; running = 0; f = 0;
                            since_tog = -1; falls = 0; first_ws = 1;
                        end
                        if (!p_wdata[0]) begin waiting = 0; running = 0; end
                        cfg_m = p_wdata;
                    end
                    6'd2: mask_m = p_wdata[1:0];
                    6'd3: clr = p_wdata[1:0];
                    default: ;
                endcase
            end
            status_m = (status_m & ~clr) | pend;
            pend = 2'b00;
            check(ack === ack_m, "R1 ack timing", {31'd0, ack}, {31'd0, ack_m});
            exp_irq = cfg_m[1] & |(status_m & mask_m);
            check(irq === exp_irq, "R9 irq per cycle", {31'd0, irq}, {31'd0, exp_irq});
            rise = !sck_p && sck;
            fall = sck_p && !sck;
            en_hist = {en_hist[2:0], cfg_m[0]};
            if (cfg_m[0]) begin
                since_tog++;
                if (sck != sck_p) begin
                    check(since_tog == int'(cfg_m[15:8]) + 1, "R3 bit clock half period",
                          since_tog, int'(cfg_m[15:8]) + 1);
                    since_tog = 0;
                end
                if (fall) falls++;
                if (ws != ws_p) begin
                    check(fall, "R4 ws changes on falling sck", {31'd0, fall}, 32'd1);
                    check(falls == (first_ws ? 1 : 32), "R4 slot length", falls, first_ws ? 1 : 32);
                    first_ws = 0; falls = 0;
                    if (!ws) begin
                        if (waiting) begin waiting = 0; running = 1; end
                        if (running) begin cur = exp_word(2*f); rise_cnt = 0; end
                    end else if (running) begin
                        cur = exp_word(2*f + 1); rise_cnt = 0;
                        if (f == 7)  pend[0] = 1'b1;
                        if (f == 15) pend[1] = 1'b1;
                        f = (f + 1) % 16;
                    end
                end
                if (rise && running) begin
                    rise_cnt++;
                    if (rise_cnt <= 32) begin
                        exp_bit = (rise_cnt == 1) ? 1'b0 : cur[33 - rise_cnt];
                        check(sd === exp_bit, "R5 serial bit", {31'd0, sd}, {31'd0, exp_bit});
                    end
                end
            end
            if (en_hist == 4'b0000)
                check(sd === 1'b0, "R6 data low while disabled", {31'd0, sd}, 32'd0);
            if (en_hist == 4'b1111 || en_hist == 4'b0000)
                check(sd_s === sd_d2, "R10 slave data lags master by 2", {31'd0, sd_s}, {31'd0, sd_d2});
            sd_d2 = sd_d1; sd_d1 = sd;
            sck_p = sck; ws_p = ws;
        end
    end

    task automatic bus_write(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk); stb = 1; we = 1; addr = a; wdata = d;
        @(negedge clk); stb = 0; we = 0;
    endtask

    task automatic bus_read(input logic [5:0] a, output logic [31:0] d, output logic [31:0] ds);
        @(negedge clk); stb = 1; we = 0; addr = a;
        @(negedge clk); d = rdata; ds = rdata_s; stb = 0;
    endtask

    task automatic wait_irq(input int lim);
        int n = 0;
        while (!irq && n < lim) begin @(negedge clk); n++; end
        check(irq === 1'b1, "R7 half-drained interrupt arrives", {31'd0, irq}, 32'd1);
    endtask

    always @(posedge clk) begin
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d, ds;
        int rises;
        logic wsq;
        repeat (4) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // reset state
        check(ack === 0 && irq === 0, "R1 reset outputs", {30'd0, ack, irq}, 0);
        check(sd === 0 && sck === 0, "R6 reset serial idle", {30'd0, sd, sck}, 0);
        check(ws === 1, "R4 reset ws high", {31'd0, ws}, 1);
        bus_read(6'd0, d, ds);
        check(d == 32'h1B1, "R1 master version", d, 32'h1B1);
        check(ds == 32'h191, "R1 slave version", ds, 32'h191);
        bus_read(6'd1, d, ds);
        check(d == 0, "R1 config after reset", d, 0);
        for (int i = 0; i < 32; i++)
            bus_write(6'h20 + 6'(i), 32'hA5C3_0000 ^ (32'h0102_0305 * (i + 1)) ^ (i[0] ? 32'h00F0_0F00 : 0));
        bus_read(6'h20, d, ds);
        check(d == buf_m[0], "R2 buffer readback left 0", d, buf_m[0]);
        bus_read(6'h3F, d, ds);
        check(d == buf_m[31], "R2 buffer readback right 15", d, buf_m[31]);
        bus_read(6'h2B, d, ds);
        check(d == buf_m[11], "R2 buffer readback right 5", d, buf_m[11]);

        // run at 24 bits until the lower half drains
        bus_write(6'd2, 32'h3);
        bus_write(6'd1, 32'h0018_0203);
        wait_irq(6000);
        bus_read(6'd3, d, ds);
        check(d == 32'h1, "R7 lower half status", d, 1);
        bus_write(6'd3, 32'h1);
        @(negedge clk);
        check(irq === 0, "R8 clear drops irq", {31'd0, irq}, 0);
        bus_write(6'd1, 32'h0);
        repeat (6) @(negedge clk);
        check(sd === 0 && sck === 0 && ws === 1, "R6 idle after disable", {29'd0, sd, sck, ws}, 1);

        // collision: clear of bit 1 on the edge that sets it, 20-bit samples
        bus_write(6'd1, 32'h0014_0203);
        rises = 0; wsq = 1;
        while (rises < 16) begin
            @(posedge clk); #1;
            if (ws && !wsq) rises++;
            wsq = ws;
        end
        bus_write(6'd3, 32'h2);
        @(negedge clk);
        check(irq === 1, "R8 set wins over clear", {31'd0, irq}, 1);
        bus_read(6'd3, d, ds);
        check(d == 32'h3, "R8 status after collision", d, 3);
        bus_write(6'd3, 32'h3);
        @(negedge clk);
        check(irq === 0, "R8 both bits cleared", {31'd0, irq}, 0);
        bus_write(6'd1, 32'h0);

        // interrupt gating at 16 bits
        bus_write(6'd1, 32'h0010_0201);
        d = 0;
        for (int n = 0; n < 3000 && d[0] == 0; n++) bus_read(6'd3, d, ds);
        check(d[0] == 1, "R7 status set with irq disabled", d, 1);
        check(irq === 0, "R9 irq gated by enable bit", {31'd0, irq}, 0);
        bus_write(6'd1, 32'h0010_0203);
        @(negedge clk);
        check(irq === 1, "R9 irq after enable bit set", {31'd0, irq}, 1);
        bus_write(6'd2, 32'h0);
        @(negedge clk);
        check(irq === 0, "R9 irq masked", {31'd0, irq}, 0);
        bus_write(6'd3, 32'h3);
        bus_write(6'd1, 32'h0);
        repeat (8) @(negedge clk);
        check(sd === 0 && sd_s === 0, "R6 both variants quiet", {30'd0, sd, sd_s}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule